// File: doc/BRIEF.md
# Acquisition cycle sequencer

This block is the top-level controller for a periodic measurement cycle. In each cycle it reads an absolute position encoder and forwards a value to a serial DAC. Two sub-blocks, not part of this design, do the serial shifting. The sequencer starts each of them with a one-clock start strobe and waits for its done pulse. The encoder reader also reports whether its SSI link check failed. A cycle only proceeds when the drive reports that it is connected, or when a reset override switch is closed. Without either, the controller keeps returning to initialisation.

After both transfers succeed, the activity LED takes the value of the configuration-analysis result. The controller then waits for a tick from an internal prescaler. On that tick it pulses the active-low DAC load strobe for one clock and begins the next cycle. An SSI fault sends the controller back to initialisation. So does a phase that makes no progress within a set number of cycles, in which case a built-in watchdog forces the return. Returning to initialisation clears the LED.

Top module: `acq_cycle_seq`

## Requirements
- R1: While reset is held and on its release, `load_n_o` is 1 and `led_o`, `enc_start_o`, `dac_start_o` and `wdog_bite_o` are 0.
- R2: An encoder start pulse (one clock of `enc_start_o` = 1) is only issued when `drive_present_i` or `override_i` was 1 in the previous cycle. With both at 0, no start ever appears.
- R3: An `enc_done_i` pulse with `enc_fault_i` = 1 gives no DAC start. The controller passes through initialisation, which clears `led_o`. With the drive present, it issues the next encoder start 3 cycles after the done cycle.
- R4: An `enc_done_i` pulse with `enc_fault_i` = 0, received during the encoder phase, gives a one-clock `dac_start_o` in the cycle that follows it.
- R5: After a `dac_done_i` pulse in the DAC phase, `led_o` takes the value of `cfg_led_i` two cycles later and keeps it until the next LED update or until initialisation.
- R6: `load_n_o` goes to 0 for exactly one clock, in the cycle after a `tick_o` pulse that arrives while the controller waits for synchronisation. It goes to 0 at no other time.
- R7: `tick_o` is a one-clock pulse that repeats every TICK_DIV cycles.
- R8: After the load pulse, with the drive still present, the next encoder start appears 2 cycles after the cycle in which `load_n_o` was 0.
- R9: If a phase makes no progress for WDOG_CYCLES cycles, `wdog_bite_o` pulses for one clock WDOG_CYCLES cycles after the phase began. The controller then returns to initialisation, which clears `led_o`. The next encoder start comes 3 cycles after the bite.
- R10: A done pulse that arrives outside the phase waiting for it has no effect: no start strobe and no load strobe. At most one of the four strobes (encoder start, DAC start, load, bite) is active in any cycle.
- R11: While the drive is absent and the override is off, the watchdog never bites, because the controller keeps moving between initialisation and the presence check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| drive_present_i | input | 1 | Drive is connected |
| override_i | input | 1 | Reset override switch is on |
| cfg_led_i | input | 1 | LED value from the configuration analysis |
| enc_start_o | output | 1 | One-clock start strobe to the encoder reader |
| enc_done_i | input | 1 | Encoder reader finished (one clock) |
| enc_fault_i | input | 1 | SSI link check failed, valid with enc_done_i |
| dac_start_o | output | 1 | One-clock start strobe to the DAC shifter |
| dac_done_i | input | 1 | DAC shifter finished (one clock) |
| load_n_o | output | 1 | Active-low DAC load strobe |
| led_o | output | 1 | Activity LED |
| tick_o | output | 1 | Periodic synchronisation tick |
| wdog_bite_o | output | 1 | Watchdog forced-reset pulse |

## Verification
On every cycle, the assertions check the local strobe rules. Each strobe lasts one clock and no two strobes overlap. A load follows a tick, a DAC start follows a clean encoder done, and an encoder start follows presence or the override. The bench scenarios are needed for the timing that spans phases. These are the exact watchdog delay, the cycles from a fault or a bite to the next start, and the cycles between load and restart. The bench also shows when the LED updates and when it clears, and that stray done pulses, or a missing drive, produce no strobe at all.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_CHECK = 3'd1,
    ST_ACQ   = 3'd2,
    ST_XFER  = 3'd3,
    ST_LED   = 3'd4,
    ST_SYNC  = 3'd5,
    ST_LOAD  = 3'd6
  } seq_state_e;

endpackage

// File: rtl/acq_rst_sync.sv
module acq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/acq_tick_gen.sv
module acq_tick_gen #(
  parameter int DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_q, wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= wrap;
    end
  end

  assign tick_o = tick_q;

endmodule

// File: rtl/acq_watchdog.sv
module acq_watchdog #(
  parameter int LIMIT = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed_i,
  input  logic advance_i,
  output logic bite_o
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          bite_q, bite_d;
  logic          clr, hit, cnt_en;

  always_comb begin
    clr    = advance_i || !armed_i;
    hit    = (cnt_q == LAST);
    cnt_en = 1'b1;
    if (clr || hit) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    bite_d = hit && !clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bite_q <= 1'b0;
    end else begin
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      bite_q <= bite_d;
    end
  end

  assign bite_o = bite_q;

endmodule

// File: rtl/acq_seq_fsm.sv
module acq_seq_fsm
  import acq_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic drive_present_i,
  input  logic override_i,
  input  logic cfg_led_i,
  input  logic enc_done_i,
  input  logic enc_fault_i,
  input  logic dac_done_i,
  input  logic tick_i,
  input  logic bite_i,
  output logic enc_start_o,
  output logic dac_start_o,
  output logic load_n_o,
  output logic led_o,
  output logic armed_o,
  output logic advance_o
);

  seq_state_e state_q, state_d;
  logic enc_start_q, enc_start_d;
  logic dac_start_q, dac_start_d;
  logic load_n_q, load_n_d;
  logic led_q, led_d, led_en;

  always_comb begin
    state_d     = state_q;
    enc_start_d = 1'b0;
    dac_start_d = 1'b0;
    load_n_d    = 1'b1;
    if (bite_i) begin
      state_d = ST_INIT;
    end else begin
      unique case (state_q)
        ST_INIT:  state_d = ST_CHECK;
        ST_CHECK: begin
          if (drive_present_i || override_i) begin
            state_d     = ST_ACQ;
            enc_start_d = 1'b1;
          end else begin
            state_d = ST_INIT;
          end
        end
        ST_ACQ: begin
          if (enc_done_i) begin
            if (enc_fault_i) begin
              state_d = ST_INIT;
            end else begin
              state_d     = ST_XFER;
              dac_start_d = 1'b1;
            end
          end
        end
        ST_XFER: begin
          if (dac_done_i) begin
            state_d = ST_LED;
          end
        end
        ST_LED:   state_d = ST_SYNC;
        ST_SYNC: begin
          if (tick_i) begin
            state_d  = ST_LOAD;
            load_n_d = 1'b0;
          end
        end
        ST_LOAD:  state_d = ST_CHECK;
        default:  state_d = ST_INIT;
      endcase
    end
  end

  always_comb begin
    led_en = (state_q == ST_LED) || (state_q == ST_INIT);
    led_d  = (state_q == ST_LED) ? cfg_led_i : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_INIT;
      enc_start_q <= 1'b0;
      dac_start_q <= 1'b0;
      load_n_q    <= 1'b1;
      led_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      enc_start_q <= enc_start_d;
      dac_start_q <= dac_start_d;
      load_n_q    <= load_n_d;
      if (led_en) begin
        led_q <= led_d;
      end
    end
  end

  assign enc_start_o = enc_start_q;
  assign dac_start_o = dac_start_q;
  assign load_n_o    = load_n_q;
  assign led_o       = led_q;
  assign armed_o     = (state_q != ST_INIT);
  assign advance_o   = (state_d != state_q);

endmodule

// File: rtl/acq_cycle_seq.sv
module acq_cycle_seq #(
  parameter int TICK_DIV    = 1000,
  parameter int WDOG_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_present_i,
  input  logic override_i,
  input  logic cfg_led_i,
  output logic enc_start_o,
  input  logic enc_done_i,
  input  logic enc_fault_i,
  output logic dac_start_o,
  input  logic dac_done_i,
  output logic load_n_o,
  output logic led_o,
  output logic tick_o,
  output logic wdog_bite_o
);

  logic rst_sync_n;
  logic tick;
  logic bite;
  logic armed;
  logic advance;

  acq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  acq_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick_o (tick)
  );

  acq_watchdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .armed_i   (armed),
    .advance_i (advance),
    .bite_o    (bite)
  );

  acq_seq_fsm u_fsm (
    .clk             (clk),
    .rst_n           (rst_sync_n),
    .drive_present_i (drive_present_i),
    .override_i      (override_i),
    .cfg_led_i       (cfg_led_i),
    .enc_done_i      (enc_done_i),
    .enc_fault_i     (enc_fault_i),
    .dac_done_i      (dac_done_i),
    .tick_i          (tick),
    .bite_i          (bite),
    .enc_start_o     (enc_start_o),
    .dac_start_o     (dac_start_o),
    .load_n_o        (load_n_o),
    .led_o           (led_o),
    .armed_o         (armed),
    .advance_o       (advance)
  );

  assign tick_o      = tick;
  assign wdog_bite_o = bite;

endmodule

// File: rtl/acq_cycle_seq_chk.sv
module acq_cycle_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic drive_present_i,
  input logic override_i,
  input logic enc_start_o,
  input logic enc_done_i,
  input logic enc_fault_i,
  input logic dac_start_o,
  input logic load_n_o,
  input logic tick_o,
  input logic wdog_bite_o
);

  // R2
  enc_start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_start_o |-> $past(drive_present_i || override_i));

  // R4
  dac_start_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_start_o |-> $past(enc_done_i && !enc_fault_i));

  // R4
  dac_start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_start_o |=> !dac_start_o);

  // R6
  load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n_o |=> load_n_o);

  // R6
  load_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n_o |-> $past(tick_o));

  // R7
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  // R9
  bite_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_bite_o |=> !wdog_bite_o);

  // R10
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({enc_start_o, dac_start_o, !load_n_o, wdog_bite_o}));

endmodule

bind acq_cycle_seq acq_cycle_seq_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .drive_present_i (drive_present_i),
  .override_i      (override_i),
  .enc_start_o     (enc_start_o),
  .enc_done_i      (enc_done_i),
  .enc_fault_i     (enc_fault_i),
  .dac_start_o     (dac_start_o),
  .load_n_o        (load_n_o),
  .tick_o          (tick_o),
  .wdog_bite_o     (wdog_bite_o)
);

// File: tb/acq_cycle_seq_tb.sv
module acq_cycle_seq_tb;

  localparam int TICK_DIV = 16;
  localparam int WDOG     = 40;

  typedef enum int {EV_ENC, EV_DAC, EV_LOAD, EV_BITE} ev_e;

  logic clk;
  logic rst_n;
  logic drive_present_i, override_i, cfg_led_i;
  logic enc_done_i, enc_fault_i, dac_done_i;
  logic enc_start_o, dac_start_o, load_n_o, led_o, tick_o, wdog_bite_o;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  acq_cycle_seq #(.TICK_DIV(TICK_DIV), .WDOG_CYCLES(WDOG)) u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .drive_present_i (drive_present_i),
    .override_i      (override_i),
    .cfg_led_i       (cfg_led_i),
    .enc_start_o     (enc_start_o),
    .enc_done_i      (enc_done_i),
    .enc_fault_i     (enc_fault_i),
    .dac_start_o     (dac_start_o),
    .dac_done_i      (dac_done_i),
    .load_n_o        (load_n_o),
    .led_o           (led_o),
    .tick_o          (tick_o),
    .wdog_bite_o     (wdog_bite_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc++;

  int n_chk = 0, n_fail = 0;
  int n_enc = 0, n_dac = 0, n_load = 0, n_bite = 0;
  int t_enc = 0, t_dac = 0, t_load = 0, t_bite = 0, t_tick = 0;
  bit tick_seen = 1'b0;

  ev_e   exp_kind[$];
  string exp_req[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_ev(input ev_e k, input string req);
    exp_kind.push_back(k);
    exp_req.push_back(req);
  endtask

  task automatic got_ev(input ev_e k);
    ev_e   ek;
    string r;
    if (exp_kind.size() == 0) begin
      chk(1'b0, "R10", "unexpected strobe", int'(k), -1);
    end else begin
      ek = exp_kind.pop_front();
      r  = exp_req.pop_front();
      chk(ek == k, r, "strobe kind", int'(k), int'(ek));
    end
  endtask

  // Monitor: pops the scoreboard as strobes appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (!load_n_o) begin
        n_load++; t_load = cyc;
        chk(tick_seen && (cyc - t_tick == 1), "R6", "load delay after tick", cyc - t_tick, 1);
        got_ev(EV_LOAD);
      end
      if (tick_o) begin
        if (tick_seen) chk(cyc - t_tick == TICK_DIV, "R7", "tick period", cyc - t_tick, TICK_DIV);
        t_tick = cyc; tick_seen = 1'b1;
      end
      if (enc_start_o) begin n_enc++;  t_enc  = cyc; got_ev(EV_ENC);  end
      if (dac_start_o) begin n_dac++;  t_dac  = cyc; got_ev(EV_DAC);  end
      if (wdog_bite_o) begin n_bite++; t_bite = cyc; got_ev(EV_BITE); end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R9", "bench watchdog expired", cyc, 20000);
    finish_run();
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic pulse_enc(input bit fault, output int k);
    step();
    enc_fault_i = fault; enc_done_i = 1'b1; k = cyc;
    step();
    enc_fault_i = 1'b0; enc_done_i = 1'b0;
  endtask

  task automatic pulse_dac(output int k);
    step();
    dac_done_i = 1'b1; k = cyc;
    step();
    dac_done_i = 1'b0;
  endtask

  task automatic wait_enc(input int s);
    while (n_enc <= s) step();
  endtask

  initial begin
    int k, s, sd, te, sb;
    rst_n = 1'b0;
    drive_present_i = 1'b0; override_i = 1'b0; cfg_led_i = 1'b0;
    enc_done_i = 1'b0; enc_fault_i = 1'b0; dac_done_i = 1'b0;
    repeat (4) step();
    // R1: outputs while reset is held
    chk(load_n_o == 1'b1, "R1", "load_n in reset", load_n_o, 1);
    chk(led_o == 1'b0, "R1", "led in reset", led_o, 0);
    rst_n = 1'b1;
    repeat (3) step();
    chk(enc_start_o == 1'b0 && dac_start_o == 1'b0, "R1", "starts after reset",
        {enc_start_o, dac_start_o}, 0);
    chk(wdog_bite_o == 1'b0, "R1", "bite after reset", wdog_bite_o, 0);

    // R2 / R10 / R11: no drive, no override, stray done pulses
    pulse_enc(1'b0, k);
    pulse_dac(k);
    repeat (60) step();
    chk(n_enc == 0, "R2", "encoder starts without drive", n_enc, 0);
    chk(n_dac == 0 && n_load == 0, "R10", "strobes from stray done", n_dac + n_load, 0);
    chk(n_bite == 0, "R11", "bites while idle", n_bite, 0);

    // R8: full cycle with drive present
    cfg_led_i = 1'b1;
    expect_ev(EV_ENC, "R2");
    s = n_enc;
    drive_present_i = 1'b1;
    wait_enc(s);
    expect_ev(EV_DAC, "R4");
    pulse_enc(1'b0, k);
    chk(t_dac == k + 1, "R4", "dac start cycle", t_dac, k + 1);
    expect_ev(EV_LOAD, "R6");
    expect_ev(EV_ENC, "R8");
    s = n_enc;
    pulse_dac(k);
    chk(led_o == 1'b0, "R5", "led one cycle after dac done", led_o, 0);
    step();
    chk(led_o == 1'b1, "R5", "led two cycles after dac done", led_o, 1);
    wait_enc(s);
    chk(t_enc == t_load + 2, "R8", "restart after load", t_enc, t_load + 2);

    // R10: dac done during encoder phase is ignored
    sd = n_dac;
    pulse_dac(k);
    repeat (2) step();
    chk(n_dac == sd && load_n_o == 1'b1, "R10", "stray dac done", n_dac - sd, 0);

    // R3: SSI fault restarts through initialisation
    expect_ev(EV_ENC, "R3");
    s = n_enc;
    pulse_enc(1'b1, k);
    wait_enc(s);
    chk(t_enc == k + 3, "R3", "restart after fault", t_enc, k + 3);
    chk(led_o == 1'b0, "R3", "led cleared by fault", led_o, 0);
    chk(n_dac == sd, "R3", "dac start after fault", n_dac - sd, 0);

    // R2: override keeps the cycle running without drive
    expect_ev(EV_DAC, "R4");
    pulse_enc(1'b0, k);
    expect_ev(EV_LOAD, "R6");
    expect_ev(EV_ENC, "R2");
    s = n_enc;
    pulse_dac(k);
    drive_present_i = 1'b0; override_i = 1'b1;
    step();
    chk(led_o == 1'b1, "R5", "led follows cfg", led_o, 1);
    wait_enc(s);
    chk(t_enc == t_load + 2, "R2", "override restart after load", t_enc, t_load + 2);

    // R9: stalled encoder phase
    te = t_enc;
    expect_ev(EV_BITE, "R9");
    expect_ev(EV_ENC, "R9");
    s = n_enc;
    sb = n_bite;
    while (n_bite <= sb) step();
    chk(t_bite - te == WDOG, "R9", "bite delay", t_bite - te, WDOG);
    wait_enc(s);
    chk(t_enc == t_bite + 3, "R9", "restart after bite", t_enc, t_bite + 3);
    chk(led_o == 1'b0, "R9", "led cleared by bite", led_o, 0);

    // R2 / R11: finish a cycle, then no presence stops the restart
    override_i = 1'b0; cfg_led_i = 1'b0;
    expect_ev(EV_DAC, "R4");
    pulse_enc(1'b0, k);
    expect_ev(EV_LOAD, "R6");
    pulse_dac(k);
    s = n_enc;
    sb = n_bite;
    repeat (80) step();
    chk(n_enc == s, "R2", "restart without presence", n_enc - s, 0);
    chk(n_bite == sb, "R11", "bite while idle", n_bite - sb, 0);
    chk(exp_kind.size() == 0, "R10", "strobes still expected", exp_kind.size(), 0);
    finish_run();
  end

endmodule